// File: doc/BRIEF.md
# Four-Channel Converter SPI Register Interface

This block is the digital register front end of a four-channel output converter. A host reaches it over a four-wire serial link in clock mode 0. The serial clock idles low. Data is sampled on its rising edge and changed on its falling edge, most significant bit first. A transaction is exactly 24 clocks long and is framed by an active-low select. Each frame holds three fields: a read flag in bit 23, a register address in bits 22:16 and a 16-bit payload in bits 15:0. The interface runs on the system clock. It synchronises the serial pins and acts on a frame only when the select returns high.

The block handles writes and reads through two different address layouts. Write frames update per-channel code, gain and offset registers. A write to a channel's control address is steered by the top three payload bits to one of several sub-registers: slew, main, DAC control, DC-DC or software. Read frames load nothing. They arm a reply, and that reply is sent in the low 16 bits of the host's next frame. The host normally fills that next frame with the no-op word 0x1CE000. All stored values are also driven on parallel outputs. The analog stage, the slew ramp and the DC-DC converter are out of scope. They appear here only as stored bits or as the status input.

The serial receiver is a two-state machine. RX_IDLE moves to RX_SHIFT when the synchronised select falls. At that moment it also loads the reply word. RX_SHIFT returns to RX_IDLE when the select rises, and it passes the frame on only if exactly 24 clocks were counted. The readback machine is also two-state. RB_IDLE moves to RB_ARMED when a complete read frame ends. RB_ARMED returns to RB_IDLE when the next frame starts and takes the reply.

Top module: `dac_spi_regif`

## Requirements
- R1: A frame is shifted in MSB first on rising serial-clock edges while cs_n is low. It is decoded only after cs_n returns high. Bit 23 is the read flag, bits 22:16 are the address and bits 15:0 are the payload.
- R2: A frame that ends after any count of rising clocks other than 24 is discarded. It neither writes a register nor arms a reply.
- R3: Write addresses 0x00–0x03 load the code register, 0x08–0x0B load the gain register and 0x10–0x13 load the offset register. In each case the full 16-bit payload is stored and address bits 1:0 pick the channel.
- R4: A write to 0x1C–0x1F with selector (payload bits 15:13) equal to 2 loads payload bits 12:0 into that channel's DAC control register. In that register, bit 8 is internal enable, bit 7 is clear enable, bit 6 is output enable, bit 5 selects the internal sense resistor, bit 4 is DC-DC enable, bit 3 is overrange enable and bits 2:0 are the range mode. Selector 0 loads that channel's slew register, where bits 2:0 are the step, bits 6:3 are the rate and bit 12 is the enable.
- R5: Selector 1 loads the shared main register from any channel's control address. Selector 3 loads the DC-DC register only through address 0x1C; in that register, bits 1:0 are the voltage limit, bits 3:2 the frequency, bits 5:4 the phase and bit 6 the external compensation. Selector 4 gives a one-cycle sw_wr pulse with the 13-bit value on sw_val. Selectors 5–7, including the no-op word 0x1CE000, change nothing.
- R6: A write frame to any other address changes no register.
- R7: The read map covers these addresses, with address bits 1:0 picking the channel: code at 0x00–0x03, DAC control at 0x04–0x07, gain at 0x08–0x0B, offset at 0x0C–0x0F, slew at 0x14–0x17. The single registers are status_in at 0x18, main at 0x19 and DC-DC at 0x1A. Values narrower than 16 bits are zero-extended.
- R8: A read request returns nothing in its own frame. The reply is sent in bits 15:0 of the next frame, with bits 23:16 zero. That frame is processed normally otherwise. A frame that does not follow a read request drives all zeros on miso.
- R9: The clear-code reads (0x10–0x13), 0x1B–0x1F and every address at or above 0x20 reply zero.
- R10: After reset, every register, miso and sw_wr are zero.
- R11: A read frame does not write, whatever its payload bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| status_in | input | 16 | Status word returned at read address 0x18 |
| data_q | output | 4x16 | Per-channel code registers |
| gain_q | output | 4x16 | Per-channel gain registers |
| offset_q | output | 4x16 | Per-channel offset registers |
| ctl_q | output | 4x13 | Per-channel DAC control registers |
| slew_q | output | 4x13 | Per-channel slew registers |
| main_q | output | 13 | Shared main register |
| dcdc_q | output | 13 | Shared DC-DC register |
| sw_wr | output | 1 | One-cycle pulse on a software-selector write |
| sw_val | output | 13 | Value of the last software-selector write |

## Verification
The bench sends every selector value to every channel's control address. A selector decode that is off by one, or a DC-DC register that accepts writes from channels 1–3, shows up as a parallel output differing from the bench's model. It sweeps every read address from 0x00 to 0x3F, plus 0x7F, each as a request followed by a no-op. A mixed-up read map, a reply sent in the request's own frame, or a reply delayed by one more frame all give a miso word that does not match. Frames of 23 and 25 clocks are sent as both writes and reads, which catches a counter that accepts a partial or overlong frame. Read requests carry all-ones payloads, which catches a design that treats them as writes.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int NCH     = 4;
    localparam int CH_W    = $clog2(NCH);
    localparam int SEL_W   = 3;
    localparam int VAL_W   = DATA_W - SEL_W;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // address group codes (address bits 4:2)
    localparam logic [2:0] WG_DATA = 3'd0;
    localparam logic [2:0] WG_GAIN = 3'd2;
    localparam logic [2:0] WG_OFFS = 3'd4;
    localparam logic [2:0] WG_CTRL = 3'd7;

    localparam logic [2:0] RG_DATA = 3'd0;
    localparam logic [2:0] RG_CTL  = 3'd1;
    localparam logic [2:0] RG_GAIN = 3'd2;
    localparam logic [2:0] RG_OFFS = 3'd3;
    localparam logic [2:0] RG_CLR  = 3'd4;
    localparam logic [2:0] RG_SLEW = 3'd5;
    localparam logic [2:0] RG_MISC = 3'd6;

    // control sub-register selectors (payload bits 15:13)
    localparam logic [SEL_W-1:0] SEL_SLEW   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MAIN   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DACCTL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DCDC   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SW     = 3'd4;

endpackage

// File: rtl/dac_spi_frame_rx.sv
module dac_spi_frame_rx
    import dac_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] tx_word,
    output frame_t             frame_q,
    output logic               frame_ok,
    output logic               frame_start,
    output logic               miso
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef enum logic {RX_IDLE, RX_SHIFT} rx_state_e;

    logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
    logic sclk_s, cs_s, mosi_s, sclk_prev;
    logic sclk_rise, sclk_fall;

    rx_state_e state_q, state_d;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx_sr, tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sy   <= '0;
            cs_sy     <= '1;
            mosi_sy   <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sy   <= {sclk_sy[SYNC_STAGES-2:0], sclk};
            cs_sy     <= {cs_sy[SYNC_STAGES-2:0], cs_n};
            mosi_sy   <= {mosi_sy[SYNC_STAGES-2:0], mosi};
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_s    = sclk_sy[SYNC_STAGES-1];
    assign cs_s      = cs_sy[SYNC_STAGES-1];
    assign mosi_s    = mosi_sy[SYNC_STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!cs_s) state_d = RX_SHIFT;
            RX_SHIFT: if (cs_s)  state_d = RX_IDLE;
            default:             state_d = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            rx_sr       <= '0;
            tx_sr       <= '0;
            frame_ok    <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_ok    <= 1'b0;
            frame_start <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (!cs_s) begin
                        cnt         <= '0;
                        tx_sr       <= tx_word;
                        frame_start <= 1'b1;
                    end
                end
                RX_SHIFT: begin
                    if (cs_s) begin
                        frame_ok <= (cnt == CNT_FULL);
                    end else begin
                        if (sclk_rise) begin
                            rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
                        end
                        if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign frame_q = rx_sr;
    assign miso    = (state_q == RX_SHIFT) && tx_sr[FRAME_W-1];

    assert_ok_after_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> ($past(state_q) == RX_SHIFT) && (state_q == RX_IDLE));
    assert_ok_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> $past(cnt) == CNT_FULL);
    assert_ok_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);
    assert_cnt_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_OVER);

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_regif_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [DATA_W-1:0]           status_in,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NCH-1:0][DATA_W-1:0]  data_q,
    output logic [NCH-1:0][DATA_W-1:0]  gain_q,
    output logic [NCH-1:0][DATA_W-1:0]  offset_q,
    output logic [NCH-1:0][VAL_W-1:0]   ctl_q,
    output logic [NCH-1:0][VAL_W-1:0]   slew_q,
    output logic [VAL_W-1:0]            main_q,
    output logic [VAL_W-1:0]            dcdc_q,
    output logic                        sw_wr,
    output logic [VAL_W-1:0]            sw_val
);

    localparam int HI_W = ADDR_W - 5;

    logic            w_in_map;
    logic [2:0]      w_grp;
    logic [CH_W-1:0] w_ch;
    logic [SEL_W-1:0] w_sel;
    logic [VAL_W-1:0] w_val;
    logic hit_data, hit_gain, hit_offs, hit_ctrl;

    assign w_in_map = (wr_addr[ADDR_W-1:5] == HI_W'(0));
    assign w_grp    = wr_addr[4:2];
    assign w_ch     = wr_addr[CH_W-1:0];
    assign w_sel    = wr_data[DATA_W-1:VAL_W];
    assign w_val    = wr_data[VAL_W-1:0];

    assign hit_data = wr_en && w_in_map && (w_grp == WG_DATA);
    assign hit_gain = wr_en && w_in_map && (w_grp == WG_GAIN);
    assign hit_offs = wr_en && w_in_map && (w_grp == WG_OFFS);
    assign hit_ctrl = wr_en && w_in_map && (w_grp == WG_CTRL);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [CH_W-1:0] CH = CH_W'(c);
        logic [DATA_W-1:0] d_r, g_r, o_r;
        logic [VAL_W-1:0]  ctl_r, slew_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_r    <= '0;
                g_r    <= '0;
                o_r    <= '0;
                ctl_r  <= '0;
                slew_r <= '0;
            end else if (w_ch == CH) begin
                if (hit_data) d_r <= wr_data;
                if (hit_gain) g_r <= wr_data;
                if (hit_offs) o_r <= wr_data;
                if (hit_ctrl && (w_sel == SEL_DACCTL)) ctl_r  <= w_val;
                if (hit_ctrl && (w_sel == SEL_SLEW))   slew_r <= w_val;
            end
        end

        assign data_q[c]   = d_r;
        assign gain_q[c]   = g_r;
        assign offset_q[c] = o_r;
        assign ctl_q[c]    = ctl_r;
        assign slew_q[c]   = slew_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            dcdc_q <= '0;
            sw_wr  <= 1'b0;
            sw_val <= '0;
        end else begin
            sw_wr <= 1'b0;
            if (hit_ctrl && (w_sel == SEL_MAIN)) main_q <= w_val;
            if (hit_ctrl && (w_sel == SEL_DCDC) && (w_ch == CH_W'(0))) dcdc_q <= w_val;
            if (hit_ctrl && (w_sel == SEL_SW)) begin
                sw_wr  <= 1'b1;
                sw_val <= w_val;
            end
        end
    end

    // read map, laid out apart from the write map
    logic [CH_W-1:0] r_ch;
    assign r_ch = rd_addr[CH_W-1:0];

    always_comb begin
        rd_data = '0;
        if (rd_addr[ADDR_W-1:5] == HI_W'(0)) begin
            case (rd_addr[4:2])
                RG_DATA: rd_data = data_q[r_ch];
                RG_CTL:  rd_data = {{SEL_W{1'b0}}, ctl_q[r_ch]};
                RG_GAIN: rd_data = gain_q[r_ch];
                RG_OFFS: rd_data = offset_q[r_ch];
                RG_CLR:  rd_data = '0;
                RG_SLEW: rd_data = {{SEL_W{1'b0}}, slew_q[r_ch]};
                RG_MISC: begin
                    case (r_ch)
                        2'd0:    rd_data = status_in;
                        2'd1:    rd_data = {{SEL_W{1'b0}}, main_q};
                        2'd2:    rd_data = {{SEL_W{1'b0}}, dcdc_q};
                        default: rd_data = '0;
                    endcase
                end
                default: rd_data = '0;
            endcase
        end
    end

    assert_quiet_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data_q) && $stable(gain_q) && $stable(offset_q)
                   && $stable(ctl_q) && $stable(slew_q) && $stable(main_q) && $stable(dcdc_q));
    assert_dcdc_via_ch0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dcdc_q) |-> $past(wr_en && (wr_addr == 7'h1C)));
    assert_sw_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> !sw_wr);

endmodule

// File: rtl/dac_spi_regif.sv
module dac_spi_regif
    import dac_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk,
    input  logic                        cs_n,
    input  logic                        mosi,
    output logic                        miso,
    input  logic [DATA_W-1:0]           status_in,
    output logic [NCH-1:0][DATA_W-1:0]  data_q,
    output logic [NCH-1:0][DATA_W-1:0]  gain_q,
    output logic [NCH-1:0][DATA_W-1:0]  offset_q,
    output logic [NCH-1:0][VAL_W-1:0]   ctl_q,
    output logic [NCH-1:0][VAL_W-1:0]   slew_q,
    output logic [VAL_W-1:0]            main_q,
    output logic [VAL_W-1:0]            dcdc_q,
    output logic                        sw_wr,
    output logic [VAL_W-1:0]            sw_val
);

    typedef enum logic {RB_IDLE, RB_ARMED} rb_state_e;

    frame_t             frame_q;
    logic               frame_ok, frame_start;
    logic [FRAME_W-1:0] tx_word;
    logic [DATA_W-1:0]  rd_data, rd_hold;
    logic               wr_en, rd_req;
    rb_state_e          rb_q, rb_d;

    dac_spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .tx_word     (tx_word),
        .frame_q     (frame_q),
        .frame_ok    (frame_ok),
        .frame_start (frame_start),
        .miso        (miso)
    );

    assign wr_en  = frame_ok && !frame_q.rd;
    assign rd_req = frame_ok &&  frame_q.rd;

    dac_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (frame_q.addr),
        .wr_data   (frame_q.data),
        .rd_addr   (frame_q.addr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .data_q    (data_q),
        .gain_q    (gain_q),
        .offset_q  (offset_q),
        .ctl_q     (ctl_q),
        .slew_q    (slew_q),
        .main_q    (main_q),
        .dcdc_q    (dcdc_q),
        .sw_wr     (sw_wr),
        .sw_val    (sw_val)
    );

    // readback state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= RB_IDLE;
        else        rb_q <= rb_d;
    end

    always_comb begin
        rb_d = rb_q;
        unique case (rb_q)
            RB_IDLE:  if (rd_req)      rb_d = RB_ARMED;
            RB_ARMED: if (frame_start) rb_d = RB_IDLE;
            default:                   rb_d = RB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_hold <= '0;
        else if (rd_req) rd_hold <= rd_data;
    end

    assign tx_word = (rb_q == RB_ARMED) ? {{(FRAME_W-DATA_W){1'b0}}, rd_hold} : '0;

    assert_arm_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q == RB_ARMED) && ($past(rb_q) == RB_IDLE) |-> $past(frame_ok && frame_q.rd));
    assert_reply_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q == RB_ARMED) && frame_start |=> (rb_q == RB_IDLE));
    assert_read_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> $stable(data_q) && $stable(gain_q) && $stable(offset_q) && !sw_wr);

endmodule

// File: tb/sim_dac_spi_regif.sv
`timescale 1ns/1ps
module sim_dac_spi_regif;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [15:0] status_in = 16'hBEEF;
    logic [3:0][15:0] data_q, gain_q, offset_q;
    logic [3:0][12:0] ctl_q, slew_q;
    logic [12:0] main_q, dcdc_q, sw_val;
    logic sw_wr;

    always #2.5 clk = ~clk;

    dac_spi_regif u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .status_in(status_in), .data_q(data_q), .gain_q(gain_q), .offset_q(offset_q),
        .ctl_q(ctl_q), .slew_q(slew_q), .main_q(main_q), .dcdc_q(dcdc_q),
        .sw_wr(sw_wr), .sw_val(sw_val)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    int sw_cnt = 0;
    logic [12:0] sw_last = '0;

    logic [15:0] m_data[4], m_gain[4], m_off[4];
    logic [12:0] m_ctl[4], m_slew[4], m_main, m_dcdc;
    int exp_sw = 0;

    always @(posedge clk) if (rst_n && sw_wr) begin
        sw_cnt++;
        sw_last = sw_val;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] r);
        r = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            wait_clk(8);
            sclk = 1'b1;
            r = {r[22:0], miso};
            wait_clk(8);
            sclk = 1'b0;
        end
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(16);
    endtask

    function automatic void model_write(input logic [6:0] a, input logic [15:0] d);
        int ch = a[1:0];
        if (a[6:5] != 0) return;
        case (a[4:2])
            3'd0: m_data[ch] = d;
            3'd2: m_gain[ch] = d;
            3'd4: m_off[ch]  = d;
            3'd7: case (d[15:13])
                3'd0: m_slew[ch] = d[12:0];
                3'd1: m_main = d[12:0];
                3'd2: m_ctl[ch] = d[12:0];
                3'd3: if (ch == 0) m_dcdc = d[12:0];
                3'd4: exp_sw++;
                default: ;
            endcase
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] model_read(input logic [6:0] a);
        int ch = a[1:0];
        if (a[6:5] != 0) return 16'h0;
        case (a[4:2])
            3'd0: return m_data[ch];
            3'd1: return {3'b0, m_ctl[ch]};
            3'd2: return m_gain[ch];
            3'd3: return m_off[ch];
            3'd5: return {3'b0, m_slew[ch]};
            3'd6: case (ch)
                0: return status_in;
                1: return {3'b0, m_main};
                2: return {3'b0, m_dcdc};
                default: return 16'h0;
            endcase
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk_regs(input string req);
        for (int c = 0; c < 4; c++) begin
            chk(req, data_q[c], m_data[c]);
            chk(req, gain_q[c], m_gain[c]);
            chk(req, offset_q[c], m_off[c]);
            chk(req, ctl_q[c], m_ctl[c]);
            chk(req, slew_q[c], m_slew[c]);
        end
        chk(req, main_q, m_main);
        chk(req, dcdc_q, m_dcdc);
        chk(req, sw_cnt, exp_sw);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d, output logic [23:0] r);
        xfer({1'b0, a, d}, 24, r);
        model_write(a, d);
    endtask

    initial begin
        logic [23:0] r;
        for (int c = 0; c < 4; c++) begin
            m_data[c] = 0; m_gain[c] = 0; m_off[c] = 0; m_ctl[c] = 0; m_slew[c] = 0;
        end
        m_main = 0; m_dcdc = 0;
        wait_clk(5);
        // R10: reset state
        chk_regs("R10");
        chk("R10 miso", miso, 0);
        chk("R10 sw_wr", sw_wr, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R3 / R1: code, gain, offset for every channel
        for (int c = 0; c < 4; c++) begin
            wr(7'h00 | c[6:0], 16'hA5C3 ^ (16'h1111 * c), r);
            chk("R8 write frame miso", r, 0);
            wr(7'h08 | c[6:0], 16'h5A00 + 16'(c * 257), r);
            wr(7'h10 | c[6:0], 16'hFFFF - 16'(c * 4099), r);
            chk_regs("R3");
        end

        // R4 / R5: every selector on every channel
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
                logic [12:0] v = 13'h1ABC ^ 13'(c * 311 + s * 97);
                wr(7'h1C | c[6:0], {s[2:0], v}, r);
                chk_regs((s == 0 || s == 2) ? "R4" : "R5");
                if (s == 4) chk("R5 sw_val", sw_last, v);
            end
        end

        // R5: no-op word changes nothing
        wr(7'h1C, 16'hE000, r);
        chk_regs("R5 noop");

        // R6: unmapped write addresses
        begin
            logic [6:0] bad[6] = '{7'h04, 7'h0D, 7'h16, 7'h18, 7'h23, 7'h7F};
            for (int i = 0; i < 6; i++) begin
                wr(bad[i], 16'h3C3C, r);
                chk_regs("R6");
            end
        end

        // R2: short and long frames
        xfer({1'b0, 7'h00, 16'h0F0F}, 23, r);
        chk_regs("R2 short write");
        xfer({1'b0, 7'h01, 16'h0F0F}, 25, r);
        chk_regs("R2 long write");
        xfer({1'b1, 7'h00, 16'h0000}, 23, r);
        xfer(24'h1CE000, 24, r);
        chk("R2 short read no reply", r, 0);
        xfer({1'b1, 7'h08, 16'h0000}, 25, r);
        xfer(24'h1CE000, 24, r);
        chk("R2 long read no reply", r, 0);

        // R7 / R8 / R9 / R11: read map sweep, request carries all-ones payload
        for (int a = 0; a < 65; a++) begin
            logic [6:0] ad = (a == 64) ? 7'h7F : a[6:0];
            logic [23:0] r0;
            xfer({1'b1, ad, 16'hFFFF}, 24, r0);
            chk("R8 request frame empty", r0, 0);
            xfer(24'h1CE000, 24, r);
            chk((ad[4:2] == 3'd4 || ad >= 7'h1B) ? "R9" : "R7", r, {8'h0, model_read(ad)});
        end
        chk_regs("R11");

        // R8: reply rides on a write frame that still takes effect
        xfer({1'b1, 7'h19, 16'h0000}, 24, r);
        wr(7'h02, 16'h7E57, r);
        chk("R8 reply on write frame", r, {8'h0, 3'b0, m_main});
        chk_regs("R8 write applied");
        xfer(24'h1CE000, 24, r);
        chk("R8 single reply", r, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule